// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the register side of the serial port of a simultaneous-sampling converter. A host talks to it over a four-wire serial link in clock mode 0: clock idle low, data sampled on the rising edge and changed on the falling edge, most significant bit first. Each frame carries a write flag, a register address and a 12-bit payload. The serial pins are oversampled in the system clock domain. The decoded configuration drives the rest of the converter through plain output pins.

The bank holds five registers: two configuration words, an alert control word and two 12-bit alert thresholds. A read is a split transaction. A frame with the write flag clear names a register, and that register's contents come back on the data-out line during the next chip-select frame. Writing one of two magic codes into the reset field of the second configuration word makes the block raise a one-cycle soft-reset or hard-reset strobe. A hard reset also returns every register to its default value.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame is 16 bits, sent and returned MSB first in clock mode 0. Frame bit 15 is the write flag (1 = write). Bits 14:12 hold the register address and bits 11:0 the payload.
- R2: A complete write frame to address 1, 3, 4 or 5 replaces that register. Address 1 keeps payload bits 9:0, and its bits 11:10 read as zero. Addresses 3, 4 and 5 keep all 12 bits.
- R3: A complete frame with the write flag clear is a read request. The next chip-select frame returns the named register in bits 11:0, with bits 15:12 at zero. A frame that follows any other frame returns all zeros.
- R4: Configuration word 1 drives these output pins: bit 9 drives os_mode, bits 8:6 drive osr_code, bit 5 drives crc_wr_en, bit 4 drives crc_rd_en, bit 3 drives alert_en, bit 2 drives res_boost, bit 1 drives ref_sel and bit 0 drives pwr_mode.
- R5: At address 2, payload bit 8 is stored and drives lane_mode. Bits 7:0 form the reset field, which is never stored and reads as zero, as do bits 11:9.
- R6: Writing 0x3C into the reset field raises soft_rst_pulse for exactly one clock. All registers keep their contents, and the lane bit of the same write is still stored.
- R7: Writing 0xFF into the reset field raises hard_rst_pulse for exactly one clock and returns every register to its default. The defaults are: word 1 = 0x000, lane bit = 0, alert word = 0x000, low threshold = 0x800, high threshold = 0x7FF.
- R8: Every other reset-field value raises neither strobe, and the two strobes never occur together.
- R9: A frame whose chip select rises before 16 rising clock edges is discarded. It neither writes a register nor makes a read request.
- R10: Writes to addresses 0, 6 and 7 change nothing. Reads of those addresses return zero.
- R11: After reset, all registers hold their defaults, both strobes are low and spi_miso is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| os_mode | output | 1 | Oversampling mode bit |
| osr_code | output | 3 | Oversampling ratio code |
| crc_wr_en | output | 1 | CRC on write frames enable |
| crc_rd_en | output | 1 | CRC on read frames enable |
| alert_en | output | 1 | Alert output enable |
| res_boost | output | 1 | Resolution boost enable |
| ref_sel | output | 1 | Reference select |
| pwr_mode | output | 1 | Power mode |
| lane_mode | output | 1 | Output-lane mode |
| alert_cfg | output | 12 | Alert control word |
| thr_low | output | 12 | Alert low threshold |
| thr_high | output | 12 | Alert high threshold |
| soft_rst_pulse | output | 1 | One-cycle soft reset strobe |
| hard_rst_pulse | output | 1 | One-cycle hard reset strobe |

## Verification
The hardest case to reach is an exact reset-code match separated cleanly from its near misses. A single wrong comparator bit would go unnoticed with hand-picked codes. The bench therefore sweeps all 256 reset-field values with the lane bit set, and checks both strobe counts and the lane output after every frame. Aborted frames of 10 and 15 bits come just short of a commit. They are followed by readbacks to show that neither a write nor a pending read survived them.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 12;
  localparam int CFG1_W  = 10;
  localparam int RSTF_W  = 8;
  localparam int LANE_BIT = 8;

  localparam logic [ADDR_W-1:0] ADR_NOP    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CFG1   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CFG2   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ALERT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_THR_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_THR_HI = 3'd5;

  localparam logic [RSTF_W-1:0] CODE_SOFT = 8'h3C;
  localparam logic [RSTF_W-1:0] CODE_HARD = 8'hFF;

  localparam logic [CFG1_W-1:0] CFG1_DEF   = '0;
  localparam logic              LANE_DEF   = 1'b0;
  localparam logic [DATA_W-1:0] ALERT_DEF  = 12'h000;
  localparam logic [DATA_W-1:0] THR_LO_DEF = 12'h800;
  localparam logic [DATA_W-1:0] THR_HI_DEF = 12'h7FF;

  typedef struct packed {
    logic       os_mode;
    logic [2:0] osr;
    logic       crc_wr;
    logic       crc_rd;
    logic       alert_en;
    logic       boost;
    logic       ref_sel;
    logic       pwr_mode;
  } cfg1_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign q[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              frame_start,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int PAD_W = FRAME_W - DATA_W;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic               vld_q, vld_d;
  logic               pend_q, pend_d;
  logic [ADDR_W-1:0]  raddr_q, raddr_d;
  logic               shift_en;

  assign shift_en = sclk_rise && cs_act && (cnt_q < CNT_W'(FRAME_W));

  always_comb begin
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    vld_d   = 1'b0;
    pend_d  = pend_q;
    raddr_d = raddr_q;
    if (frame_start) begin
      cnt_d  = '0;
      pend_d = 1'b0;
      tx_d   = pend_q ? {{PAD_W{1'b0}}, rd_data} : '0;
    end else begin
      if (shift_en) begin
        rx_d  = {rx_q[FRAME_W-2:0], mosi_s};
        cnt_d = cnt_q + 1'b1;
        vld_d = (cnt_q == CNT_W'(FRAME_W - 1));
      end
      if (sclk_fall && cs_act) begin
        tx_d = {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
    if (vld_q && !rx_q[FRAME_W-1]) begin
      pend_d  = 1'b1;
      raddr_d = rx_q[FRAME_W-2 -: ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      vld_q   <= 1'b0;
      pend_q  <= 1'b0;
      raddr_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      vld_q   <= vld_d;
      pend_q  <= pend_d;
      raddr_q <= raddr_d;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_wr    = rx_q[FRAME_W-1];
  assign cmd_addr  = rx_q[FRAME_W-2 -: ADDR_W];
  assign cmd_data  = rx_q[DATA_W-1:0];
  assign rd_addr   = raddr_q;
  assign miso      = tx_q[FRAME_W-1];

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));
  // R9
  full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> cnt_q == CNT_W'(FRAME_W));
  // R3
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R3
  pend_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !vld_q) |=> !pend_q);
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output cfg1_t             cfg1,
  output logic              lane,
  output logic [DATA_W-1:0] alert,
  output logic [DATA_W-1:0] thr_lo,
  output logic [DATA_W-1:0] thr_hi,
  output logic              soft_pulse,
  output logic              hard_pulse
);
  logic [CFG1_W-1:0] cfg1_q, cfg1_d;
  logic              lane_q, lane_d;
  logic [DATA_W-1:0] alert_q, alert_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [DATA_W-1:0] hi_q, hi_d;
  logic              soft_q, soft_d;
  logic              hard_q, hard_d;
  logic              cfg2_wr;

  assign cfg2_wr = wr_en && (wr_addr == ADR_CFG2);

  always_comb begin
    cfg1_d  = cfg1_q;
    lane_d  = lane_q;
    alert_d = alert_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    soft_d  = cfg2_wr && (wr_data[RSTF_W-1:0] == CODE_SOFT);
    hard_d  = cfg2_wr && (wr_data[RSTF_W-1:0] == CODE_HARD);
    if (wr_en) begin
      case (wr_addr)
        ADR_CFG1:   cfg1_d  = wr_data[CFG1_W-1:0];
        ADR_CFG2:   lane_d  = wr_data[LANE_BIT];
        ADR_ALERT:  alert_d = wr_data;
        ADR_THR_LO: lo_d    = wr_data;
        ADR_THR_HI: hi_d    = wr_data;
        default: ;
      endcase
    end
    if (hard_d) begin
      cfg1_d  = CFG1_DEF;
      lane_d  = LANE_DEF;
      alert_d = ALERT_DEF;
      lo_d    = THR_LO_DEF;
      hi_d    = THR_HI_DEF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q  <= CFG1_DEF;
      lane_q  <= LANE_DEF;
      alert_q <= ALERT_DEF;
      lo_q    <= THR_LO_DEF;
      hi_q    <= THR_HI_DEF;
      soft_q  <= 1'b0;
      hard_q  <= 1'b0;
    end else begin
      cfg1_q  <= cfg1_d;
      lane_q  <= lane_d;
      alert_q <= alert_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      soft_q  <= soft_d;
      hard_q  <= hard_d;
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_CFG1:   rd_data = {{(DATA_W-CFG1_W){1'b0}}, cfg1_q};
      ADR_CFG2:   rd_data = {{(DATA_W-LANE_BIT-1){1'b0}}, lane_q, {RSTF_W{1'b0}}};
      ADR_ALERT:  rd_data = alert_q;
      ADR_THR_LO: rd_data = lo_q;
      ADR_THR_HI: rd_data = hi_q;
      default:    rd_data = '0;
    endcase
  end

  assign cfg1       = cfg1_t'(cfg1_q);
  assign lane       = lane_q;
  assign alert      = alert_q;
  assign thr_lo     = lo_q;
  assign thr_hi     = hi_q;
  assign soft_pulse = soft_q;
  assign hard_pulse = hard_q;

  // R2
  cfg1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CFG1) |=> cfg1_q == $past(wr_data[CFG1_W-1:0]));
  // R6
  soft_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> !soft_q);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(soft_q && hard_q));
  // R7
  hard_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |-> (cfg1_q == CFG1_DEF && lane_q == LANE_DEF && alert_q == ALERT_DEF
                && lo_q == THR_LO_DEF && hi_q == THR_HI_DEF));
  // R10
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADR_NOP || wr_addr > ADR_THR_HI)) |=>
      ($stable(cfg1_q) && $stable(lane_q) && $stable(alert_q) && $stable(lo_q) && $stable(hi_q)));
  // R5
  rstfield_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADR_CFG2) |-> rd_data[RSTF_W-1:0] == '0);
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        os_mode,
  output logic [2:0]  osr_code,
  output logic        crc_wr_en,
  output logic        crc_rd_en,
  output logic        alert_en,
  output logic        res_boost,
  output logic        ref_sel,
  output logic        pwr_mode,
  output logic        lane_mode,
  output logic [11:0] alert_cfg,
  output logic [11:0] thr_low,
  output logic [11:0] thr_high,
  output logic        soft_rst_pulse,
  output logic        hard_rst_pulse
);
  logic [1:0] rst_sq;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  logic [2:0] pins_s;
  pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({spi_sclk, spi_cs_n, spi_mosi}),
    .q    (pins_s)
  );

  logic [1:0] prev_q, prev_d;
  always_comb prev_d = pins_s[2:1];
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) prev_q <= 2'b01;
    else            prev_q <= prev_d;
  end

  logic sclk_rise, sclk_fall, cs_act, frame_start;
  assign sclk_rise   =  pins_s[2] && !prev_q[1];
  assign sclk_fall   = !pins_s[2] &&  prev_q[1];
  assign cs_act      = !pins_s[1];
  assign frame_start = !pins_s[1] &&  prev_q[0];

  logic              cmd_valid, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr, rd_addr;
  logic [DATA_W-1:0] cmd_data, rd_data;

  spi_frame_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cs_act     (cs_act),
    .frame_start(frame_start),
    .mosi_s     (pins_s[0]),
    .rd_data    (rd_data),
    .cmd_valid  (cmd_valid),
    .cmd_wr     (cmd_wr),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .rd_addr    (rd_addr),
    .miso       (spi_miso)
  );

  cfg1_t cfg1;
  spi_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (cmd_valid && cmd_wr),
    .wr_addr   (cmd_addr),
    .wr_data   (cmd_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cfg1      (cfg1),
    .lane      (lane_mode),
    .alert     (alert_cfg),
    .thr_lo    (thr_low),
    .thr_hi    (thr_high),
    .soft_pulse(soft_rst_pulse),
    .hard_pulse(hard_rst_pulse)
  );

  assign os_mode   = cfg1.os_mode;
  assign osr_code  = cfg1.osr;
  assign crc_wr_en = cfg1.crc_wr;
  assign crc_rd_en = cfg1.crc_rd;
  assign alert_en  = cfg1.alert_en;
  assign res_boost = cfg1.boost;
  assign ref_sel   = cfg1.ref_sel;
  assign pwr_mode  = cfg1.pwr_mode;
endmodule

// File: tb/tb_spi_cfg_slave.sv
module tb_spi_cfg_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, os_mode, crc_wr_en, crc_rd_en, alert_en, res_boost, ref_sel, pwr_mode, lane_mode;
  logic [2:0] osr_code;
  logic [11:0] alert_cfg, thr_low, thr_high;
  logic soft_p, hard_p;
  int n_chk = 0, n_fail = 0, soft_cnt = 0, hard_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .os_mode(os_mode), .osr_code(osr_code), .crc_wr_en(crc_wr_en),
    .crc_rd_en(crc_rd_en), .alert_en(alert_en), .res_boost(res_boost), .ref_sel(ref_sel),
    .pwr_mode(pwr_mode), .lane_mode(lane_mode), .alert_cfg(alert_cfg), .thr_low(thr_low),
    .thr_high(thr_high), .soft_rst_pulse(soft_p), .hard_rst_pulse(hard_p)
  );

  always @(posedge clk) begin
    if (soft_p) soft_cnt++;
    if (hard_p) hard_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: MSB first, host changes data while sclk low, samples miso before rising edge
  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[15-i];
      wait_clk(6);
      rx = {rx[14:0], miso};
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    logic [15:0] r;
    xfer({1'b1, a, d}, 16, r);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] r);
    logic [15:0] dummy;
    xfer({1'b0, a, 12'h000}, 16, dummy);
    xfer(16'h0000, 16, r);
  endtask

  function automatic logic [11:0] mask_of(input logic [2:0] a);
    case (a)
      3'd1: return 12'h3FF;
      3'd2: return 12'h100;
      3'd3, 3'd4, 3'd5: return 12'hFFF;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [9:0] cfg1_pins();
    return {os_mode, osr_code, crc_wr_en, crc_rd_en, alert_en, res_boost, ref_sel, pwr_mode};
  endfunction

  function automatic logic [48:0] all_state();
    return {cfg1_pins(), lane_mode, alert_cfg, thr_low, thr_high};
  endfunction

  localparam logic [48:0] DEF_STATE = {10'h000, 1'b0, 12'h000, 12'h800, 12'h7FF};

  initial begin
    logic [15:0] r;
    logic [11:0] v;
    logic [48:0] snap;
    int s0, h0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    // R11 reset state
    chk("R11 reset state", {15'b0, all_state()}, {15'b0, DEF_STATE});
    chk("R11 miso low", miso, 0);
    chk("R11 strobes low", {soft_p, hard_p}, 0);
    for (int k = 1; k <= 5; k++) begin
      rd(3'(k), r);
      chk("R11 default readback", r, {4'h0, DEF_STATE[48:37] & 12'h000} | {4'h0,
          (k == 4) ? 12'h800 : (k == 5) ? 12'h7FF : 12'h000});
    end

    // R2 R3 walking-ones and patterned writes with readback
    for (int a = 1; a <= 5; a++) begin
      for (int b = 0; b < 14; b++) begin
        v = (b < 12) ? (12'h001 << b) : (b == 12 ? 12'h000 : 12'hA5A);
        wr(3'(a), v);
        rd(3'(a), r);
        chk("R2 R3 readback", r, {4'h0, v & mask_of(3'(a))});
        case (a)
          1: chk("R4 cfg1 pins", cfg1_pins(), v[9:0]);
          2: chk("R5 lane pin", lane_mode, v[8]);
          3: chk("R2 alert pin", alert_cfg, v);
          4: chk("R2 low thr pin", thr_low, v);
          default: chk("R2 high thr pin", thr_high, v);
        endcase
      end
    end

    // R4 ratio code sweep
    for (int c = 0; c < 8; c++) begin
      wr(3'd1, 12'(c << 6) | 12'h004);
      chk("R4 osr_code", osr_code, c);
      chk("R4 res_boost", res_boost, 1);
    end

    // R3 response only in the following frame; after a write it is zero
    wr(3'd3, 12'hABC);
    xfer(16'h0000, 16, r);
    chk("R3 zero after write", r, 0);
    rd(3'd3, r);
    xfer(16'h0000, 16, r);
    chk("R3 zero after nop read", r, 0);

    // R6 soft reset keeps registers, stores lane bit
    wr(3'd1, 12'h2A5); wr(3'd2, 12'h000); wr(3'd4, 12'h123); wr(3'd5, 12'h456);
    s0 = soft_cnt; h0 = hard_cnt;
    wr(3'd2, 12'h13C);
    chk("R6 soft strobe once", soft_cnt - s0, 1);
    chk("R6 no hard strobe", hard_cnt - h0, 0);
    chk("R6 cfg1 kept", cfg1_pins(), 10'h2A5);
    chk("R6 thresholds kept", {thr_low, thr_high}, 24'h123456);
    chk("R6 lane stored", lane_mode, 1);
    rd(3'd2, r);
    chk("R5 reset field reads zero", r, 16'h0100);

    // R7 hard reset
    wr(3'd3, 12'h777);
    s0 = soft_cnt; h0 = hard_cnt;
    wr(3'd2, 12'h1FF);
    chk("R7 hard strobe once", hard_cnt - h0, 1);
    chk("R7 no soft strobe", soft_cnt - s0, 0);
    chk("R7 defaults restored", {15'b0, all_state()}, {15'b0, DEF_STATE});
    rd(3'd4, r);
    chk("R7 low thr readback", r, 16'h0800);

    // R8 all reset-field codes
    for (int code = 0; code < 256; code++) begin
      s0 = soft_cnt; h0 = hard_cnt;
      wr(3'd2, {4'h1, 8'(code)});
      chk("R8 soft strobe count", soft_cnt - s0, (code == 8'h3C) ? 1 : 0);
      chk("R8 hard strobe count", hard_cnt - h0, (code == 8'hFF) ? 1 : 0);
      chk("R8 lane after code", lane_mode, (code == 8'hFF) ? 0 : 1);
    end

    // R9 aborted frames
    wr(3'd1, 12'h0F0);
    snap = all_state();
    xfer({1'b1, 3'd1, 12'h30F}, 10, r);
    xfer({1'b1, 3'd4, 12'hFFF}, 15, r);
    chk("R9 aborted writes discarded", {15'b0, all_state()}, {15'b0, snap});
    xfer({1'b0, 3'd1, 12'h000}, 15, r);
    xfer(16'h0000, 16, r);
    chk("R9 aborted read gives zero", r, 0);

    // R10 ignored addresses
    snap = all_state();
    wr(3'd6, 12'hFFF); wr(3'd7, 12'hFFF); wr(3'd0, 12'hFFF);
    chk("R10 state unchanged", {15'b0, all_state()}, {15'b0, snap});
    rd(3'd6, r);
    chk("R10 read addr 6", r, 0);
    rd(3'd7, r);
    chk("R10 read addr 7", r, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule